// File: doc/BRIEF.md
# Indexed Status and Interrupt Register Port

This block is the host-facing side of a real-time-clock style peripheral. A host reaches a 128-byte register file through two addresses. A write to the even address selects a byte by storing a 7-bit index. An access to the odd address reads or writes the selected byte. Four of the bytes are status and control registers. The rest are plain storage.

The timekeeping counter and the rate generator sit outside this block. They reach it in two ways. Single-cycle request pins set the periodic, alarm and update-ended flags and move the update-in-progress indication. Control outputs carry the rate, divider and enable fields back to them. The flags are merged into one active-high interrupt line. A read of the flag register returns its contents, clears it and drops the line.

Two finite-state machines carry the sequential behaviour:
- **Update-in-progress machine.** It has two states, `UPD_IDLE` and `UPD_BUSY`.
  - *start* moves `UPD_IDLE` to `UPD_BUSY`. It is taken on an update-start request while SET mode is off.
  - *finish* moves `UPD_BUSY` to `UPD_IDLE`. It is taken on an update-done request.
  - *abort* moves `UPD_BUSY` to `UPD_IDLE`. It is taken on a write of the mode register with SET high.
- **Interrupt-line machine.** It has two states, `IRQ_LOW` and `IRQ_HIGH`.
  - *raise* moves `IRQ_LOW` to `IRQ_HIGH`. It is taken on a flag request whose enable is set.
  - *acknowledge* moves `IRQ_HIGH` to `IRQ_LOW`. It is taken on a read of the flag register with no enabled request in the same cycle.
  - *quiesce* moves `IRQ_HIGH` to `IRQ_LOW`. It is taken on soft reset.

Register indices are 10 (rate register, A), 11 (mode register, B), 12 (flag register, C) and 13 (fixed status register, D).

Top module: `idx_regport`

## Requirements
- R1: A write to the even address (`bus_addr`=0) stores `bus_wdata[6:0]` as the index. A read of the even address returns 0xFF.
- R2: An odd-address write to any index other than 10 to 13 stores the byte. A later odd-address read at that index returns it.
- R3: Writes to index 12 (C) and index 13 (D) are ignored. D always reads 0x80, and C keeps its flags.
- R4: Bit 7 of A (update in progress) ignores writes and keeps its value. An `upd_start` pulse sets it unless B bit 7 (SET) is high. An `upd_done` pulse clears it.
- R5: A write to B with bit 7 high clears A bit 7 and stores B bit 4 as 0, whatever the written value of bit 4.
- R6: C bit 6 is set by `pf_req`, bit 5 by `af_req` and bit 4 by `uf_req`, regardless of enables. C bit 7 is set when a request arrives while its enable is high: B bit 6 for periodic, B bit 5 for alarm, B bit 4 for update.
- R7: `irq_o` is high exactly while C bit 7 is set.
- R8: An odd-address read at index 12 returns the current value of C. Afterwards C is 0x00 and `irq_o` is low.
- R9: A flag request in the same cycle as a read of C is not lost. The read returns the old value, and the new flag, together with bit 7 if its enable is high, is visible in the following read.
- R10: After `por_n` is released, A reads 0x26, B 0x02, C 0x00 and D 0x80, and `irq_o` is low.
- R11: A `soft_rst` pulse clears B bits 6, 5 and 3 and C bits 7 to 4, and lowers `irq_o`. All other B bits, A, the index and the storage bytes keep their values.
- R12: `rate_sel` is A[3:0] and `osc_sel` is A[6:4]. `set_mode`, `pie_en`, `aie_en`, `uie_en`, `sqw_en`, `bin_mode` and `hr24_mode` are B bits 7, 6, 5, 4, 3, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| soft_rst | input | 1 | Soft reset of enables and flags, active high |
| bus_addr | input | 1 | 0 selects the index address, 1 the data address |
| bus_wr | input | 1 | Write strobe; has priority over `bus_rd` |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| pf_req | input | 1 | Periodic flag set request |
| af_req | input | 1 | Alarm flag set request |
| uf_req | input | 1 | Update-ended flag set request |
| upd_start | input | 1 | Update-in-progress set request |
| upd_done | input | 1 | Update-in-progress clear request |
| irq_o | output | 1 | Interrupt line, active high |
| rate_sel | output | 4 | Rate field of A |
| osc_sel | output | 3 | Divider field of A |
| set_mode | output | 1 | SET mode bit of B |
| pie_en | output | 1 | Periodic interrupt enable |
| aie_en | output | 1 | Alarm interrupt enable |
| uie_en | output | 1 | Update interrupt enable |
| sqw_en | output | 1 | Square-wave enable |
| bin_mode | output | 1 | Binary data mode |
| hr24_mode | output | 1 | 24-hour mode |

## Verification
The bench builds the block with its default `IDX_W` of 7. With that width the full 128-byte space is reachable, and it can show that index bit 7 of the written byte is dropped: writing 0xFA selects index 0x7A. Storage bytes on both sides of the status window (0x00, 0x0E, 0x7A) are exercised. The window itself is checked for ignored writes. Flag timing is probed in the cycle where a source request collides with the clearing read, and in the cycle right after a soft reset.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int DATA_W = 8;

    localparam int IDX_A = 10;
    localparam int IDX_B = 11;
    localparam int IDX_C = 12;
    localparam int IDX_D = 13;

    localparam logic [DATA_W-1:0] A_INIT = 8'h26;
    localparam logic [DATA_W-1:0] B_INIT = 8'h02;
    localparam logic [DATA_W-1:0] D_INIT = 8'h80;
    localparam logic [DATA_W-1:0] IDX_RD_VAL = 8'hFF;

    localparam int B_SET = 7;
    localparam int B_PIE = 6;
    localparam int B_AIE = 5;
    localparam int B_UIE = 4;
    localparam int B_SQW = 3;
    localparam int B_DM  = 2;
    localparam int B_24H = 1;

    localparam int N_SRC = 3;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_IDX_RD,
        ACC_DAT_WR,
        ACC_DAT_RD
    } acc_e;

    typedef enum logic {
        UPD_IDLE,
        UPD_BUSY
    } upd_e;

    typedef enum logic {
        IRQ_LOW,
        IRQ_HIGH
    } irq_e;
endpackage

// File: rtl/rtcp_host_port.sv
module rtcp_host_port
    import rtcp_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output acc_e              acc,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        if (bus_wr)
            acc = bus_addr ? ACC_DAT_WR : ACC_IDX_WR;
        else if (bus_rd)
            acc = bus_addr ? ACC_DAT_RD : ACC_IDX_RD;
        else
            acc = ACC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!por_n)
            idx <= '0;
        else if (acc == ACC_IDX_WR)
            idx <= bus_wdata[IDX_W-1:0];
    end

    assert_idx_latch_R1: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && !bus_addr) |=> (idx == $past(bus_wdata[IDX_W-1:0])));

    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_wr && !bus_addr) |=> $stable(idx));
endmodule

// File: rtl/rtcp_ctrl_regs.sv
module rtcp_ctrl_regs
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b
);
    upd_e              state_q, state_d;
    logic [DATA_W-2:0] a_lo_q;
    logic [DATA_W-1:0] b_q, b_d;
    logic              set_wr;
    logic              uip;

    assign set_wr = wr_b && wdata[B_SET];

    // Update-in-progress machine: state register
    always_ff @(posedge clk) begin
        if (!por_n)
            state_q <= A_INIT[DATA_W-1] ? UPD_BUSY : UPD_IDLE;
        else
            state_q <= state_d;
    end

    // Update-in-progress machine: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE: if (upd_start && !b_q[B_SET] && !set_wr) state_d = UPD_BUSY;
            UPD_BUSY: if (upd_done || set_wr)                   state_d = UPD_IDLE;
        endcase
    end

    // Update-in-progress machine: outputs
    always_comb begin
        uip = (state_q == UPD_BUSY);
    end

    always_ff @(posedge clk) begin
        if (!por_n)
            a_lo_q <= A_INIT[DATA_W-2:0];
        else if (wr_a)
            a_lo_q <= wdata[DATA_W-2:0];
    end

    always_comb begin
        b_d = b_q;
        if (wr_b) begin
            b_d = wdata;
            if (wdata[B_SET])
                b_d[B_UIE] = 1'b0;
        end
        if (soft_rst) begin
            b_d[B_PIE] = 1'b0;
            b_d[B_AIE] = 1'b0;
            b_d[B_SQW] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n)
            b_q <= B_INIT;
        else
            b_q <= b_d;
    end

    assign reg_a = {uip, a_lo_q};
    assign reg_b = b_q;

    assert_uip_keep_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wr_a && !upd_start && !upd_done && !set_wr) |=> (reg_a[DATA_W-1] == $past(reg_a[DATA_W-1])));

    assert_set_blocks_uip_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!reg_a[DATA_W-1] && reg_b[B_SET]) |=> !reg_a[DATA_W-1]);

    assert_set_forces_R5: assert property (@(posedge clk) disable iff (!por_n)
        (wr_b && wdata[B_SET]) |=> (!reg_a[DATA_W-1] && !reg_b[B_UIE]));

    assert_soft_en_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (!reg_b[B_PIE] && !reg_b[B_AIE] && !reg_b[B_SQW]));
endmodule

// File: rtl/rtcp_flag_unit.sv
module rtcp_flag_unit
    import rtcp_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          soft_rst,
    input  logic [NS-1:0] src_req,
    input  logic [NS-1:0] src_en,
    input  logic          rd_c,
    output logic [NS-1:0] flags,
    output logic          irq_o
);
    irq_e state_q, state_d;
    logic hit;

    assign hit = |(src_req & src_en);

    // one sticky flag per source
    for (genvar i = 0; i < NS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!por_n)
                flags[i] <= 1'b0;
            else if (soft_rst)
                flags[i] <= 1'b0;
            else if (src_req[i])
                flags[i] <= 1'b1;
            else if (rd_c)
                flags[i] <= 1'b0;
        end

        assert_no_lost_flag_R9: assert property (@(posedge clk) disable iff (!por_n)
            (rd_c && !soft_rst && src_req[i]) |=> flags[i]);
    end

    // Interrupt-line machine: state register
    always_ff @(posedge clk) begin
        if (!por_n)
            state_q <= IRQ_LOW;
        else
            state_q <= state_d;
    end

    // Interrupt-line machine: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_LOW:  if (hit && !soft_rst) state_d = IRQ_HIGH;
            IRQ_HIGH: if (soft_rst || (rd_c && !hit)) state_d = IRQ_LOW;
        endcase
    end

    // Interrupt-line machine: outputs
    always_comb begin
        irq_o = (state_q == IRQ_HIGH);
    end

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(irq_o) |-> $past(hit));

    assert_rdc_drop_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rd_c && !(|src_req)) |=> (flags == '0 && !irq_o));

    assert_soft_quiet_R11: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> (flags == '0 && !irq_o));
endmodule

// File: rtl/idx_regport.sv
module idx_regport
    import rtcp_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pf_req,
    input  logic              af_req,
    input  logic              uf_req,
    input  logic              upd_start,
    input  logic              upd_done,
    output logic              irq_o,
    output logic [3:0]        rate_sel,
    output logic [2:0]        osc_sel,
    output logic              set_mode,
    output logic              pie_en,
    output logic              aie_en,
    output logic              uie_en,
    output logic              sqw_en,
    output logic              bin_mode,
    output logic              hr24_mode
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] I_A = IDX_W'(IDX_A);
    localparam logic [IDX_W-1:0] I_B = IDX_W'(IDX_B);
    localparam logic [IDX_W-1:0] I_C = IDX_W'(IDX_C);
    localparam logic [IDX_W-1:0] I_D = IDX_W'(IDX_D);

    acc_e              acc;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] reg_a, reg_b, reg_c, d_q;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  src_req, src_en;
    logic              in_window, wr_a, wr_b, wr_mem, rd_c;
    logic [DATA_W-1:0] mem [DEPTH];

    rtcp_host_port #(.IDX_W(IDX_W)) u_port (
        .clk       (clk),
        .por_n     (por_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .acc       (acc),
        .idx       (idx)
    );

    assign in_window = (idx == I_A) || (idx == I_B) || (idx == I_C) || (idx == I_D);
    assign wr_a   = (acc == ACC_DAT_WR) && (idx == I_A);
    assign wr_b   = (acc == ACC_DAT_WR) && (idx == I_B);
    assign wr_mem = (acc == ACC_DAT_WR) && !in_window;
    assign rd_c   = (acc == ACC_DAT_RD) && (idx == I_C);

    rtcp_ctrl_regs u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .soft_rst  (soft_rst),
        .wr_a      (wr_a),
        .wr_b      (wr_b),
        .wdata     (bus_wdata),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .reg_a     (reg_a),
        .reg_b     (reg_b)
    );

    // source order: 0 update, 1 alarm, 2 periodic (matches C bits 4..6)
    assign src_req = {pf_req, af_req, uf_req};
    assign src_en  = {reg_b[B_PIE], reg_b[B_AIE], reg_b[B_UIE]};

    rtcp_flag_unit #(.NS(N_SRC)) u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .src_req  (src_req),
        .src_en   (src_en),
        .rd_c     (rd_c),
        .flags    (flags),
        .irq_o    (irq_o)
    );

    assign reg_c = {irq_o, flags, {(DATA_W-1-N_SRC){1'b0}}};

    always_ff @(posedge clk) begin
        if (!por_n)
            d_q <= D_INIT;
    end

    always_ff @(posedge clk) begin
        if (wr_mem)
            mem[idx] <= bus_wdata;
    end

    always_comb begin
        if (!bus_addr)
            bus_rdata = IDX_RD_VAL;
        else if (idx == I_A)
            bus_rdata = reg_a;
        else if (idx == I_B)
            bus_rdata = reg_b;
        else if (idx == I_C)
            bus_rdata = reg_c;
        else if (idx == I_D)
            bus_rdata = d_q;
        else
            bus_rdata = mem[idx];
    end

    assign rate_sel  = reg_a[3:0];
    assign osc_sel   = reg_a[6:4];
    assign set_mode  = reg_b[B_SET];
    assign pie_en    = reg_b[B_PIE];
    assign aie_en    = reg_b[B_AIE];
    assign uie_en    = reg_b[B_UIE];
    assign sqw_en    = reg_b[B_SQW];
    assign bin_mode  = reg_b[B_DM];
    assign hr24_mode = reg_b[B_24H];

    assert_c_ro_R3: assert property (@(posedge clk) disable iff (!por_n)
        ((acc == ACC_DAT_WR) && (idx == I_C) && !(|src_req) && !soft_rst) |=> (reg_c == $past(reg_c)));

    assert_irq_bit_R7: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr && bus_rd && !bus_wr && idx == I_C) |-> (bus_rdata[DATA_W-1] == irq_o));
endmodule

// File: tb/sim_idx_regport.sv
`timescale 1ns/1ps
module sim_idx_regport;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pf_req = 1'b0, af_req = 1'b0, uf_req = 1'b0;
    logic       upd_start = 1'b0, upd_done = 1'b0;
    logic       irq_o;
    logic [3:0] rate_sel;
    logic [2:0] osc_sel;
    logic       set_mode, pie_en, aie_en, uie_en, sqw_en, bin_mode, hr24_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idx_regport u0 (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_req(pf_req), .af_req(af_req), .uf_req(uf_req),
        .upd_start(upd_start), .upd_done(upd_done), .irq_o(irq_o),
        .rate_sel(rate_sel), .osc_sel(osc_sel), .set_mode(set_mode),
        .pie_en(pie_en), .aie_en(aie_en), .uie_en(uie_en), .sqw_en(sqw_en),
        .bin_mode(bin_mode), .hr24_mode(hr24_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] i, input logic [7:0] d);
        bus_write(1'b0, i);
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] i, output logic [7:0] d);
        bus_write(1'b0, i);
        bus_read(1'b1, d);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic t_power_up;
        logic [7:0] v;
        reg_read(8'd10, v); chk("R10 A", v, 8'h26);
        reg_read(8'd11, v); chk("R10 B", v, 8'h02);
        reg_read(8'd12, v); chk("R10 C", v, 8'h00);
        reg_read(8'd13, v); chk("R10 D", v, 8'h80);
        chk("R10 irq", {7'd0, irq_o}, 8'h00);
        chk("R12 rate", {4'd0, rate_sel}, 8'h06);
        chk("R12 osc", {5'd0, osc_sel}, 8'h02);
        chk("R12 b-bits", {set_mode, pie_en, aie_en, uie_en, sqw_en, bin_mode, hr24_mode, 1'b0}, 8'h02);
    endtask

    task automatic t_index_storage;
        logic [7:0] v;
        bus_write(1'b0, 8'hFA);           // index 0x7A, bit 7 dropped
        bus_write(1'b1, 8'h5A);
        reg_write(8'h00, 8'h33);
        reg_write(8'h0E, 8'hC4);
        bus_read(1'b0, v); chk("R1 even read", v, 8'hFF);
        reg_read(8'h7A, v); chk("R1 index 7 bits", v, 8'h5A);
        reg_read(8'h00, v); chk("R2 byte 0x00", v, 8'h33);
        reg_read(8'h0E, v); chk("R2 byte 0x0E", v, 8'hC4);
    endtask

    task automatic t_read_only;
        logic [7:0] v;
        pulse(uf_req);
        reg_write(8'd12, 8'hEF);
        reg_write(8'd13, 8'h00);
        reg_read(8'd13, v); chk("R3 D ignores write", v, 8'h80);
        reg_read(8'd12, v); chk("R3 C ignores write", v, 8'h10);
        chk("R6 no irq without enable", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_uip;
        logic [7:0] v;
        pulse(upd_start);
        reg_read(8'd10, v); chk("R4 uip set", v, 8'hA6);
        reg_write(8'd10, 8'h05);
        reg_read(8'd10, v); chk("R4 uip kept on write", v, 8'h85);
        chk("R12 rate after write", {4'd0, rate_sel}, 8'h05);
        chk("R12 osc after write", {5'd0, osc_sel}, 8'h00);
        pulse(upd_done);
        reg_read(8'd10, v); chk("R4 uip cleared", v, 8'h05);
        reg_write(8'd10, 8'hA6);
        reg_read(8'd10, v); chk("R4 write cannot set uip", v, 8'h26);
    endtask

    task automatic t_set_mode;
        logic [7:0] v;
        reg_write(8'd11, 8'h12);
        pulse(upd_start);
        reg_write(8'd11, 8'h92);
        reg_read(8'd11, v); chk("R5 uie forced 0", v, 8'h82);
        reg_read(8'd10, v); chk("R5 uip cleared by SET", v, 8'h26);
        chk("R12 set_mode", {7'd0, set_mode}, 8'h01);
        pulse(upd_start);
        reg_read(8'd10, v); chk("R4 start ignored in SET", v, 8'h26);
        reg_write(8'd11, 8'h02);
    endtask

    task automatic t_flags;
        logic [7:0] v;
        reg_write(8'd11, 8'h72);
        pulse(pf_req);
        chk("R7 irq high", {7'd0, irq_o}, 8'h01);
        reg_read(8'd12, v); chk("R6 periodic", v, 8'hC0);
        chk("R8 irq low after read", {7'd0, irq_o}, 8'h00);
        reg_read(8'd12, v); chk("R8 C cleared", v, 8'h00);
        pulse(af_req);
        reg_read(8'd12, v); chk("R6 alarm", v, 8'hA0);
        reg_write(8'd11, 8'h02);
        pulse(uf_req);
        chk("R7 irq low no enable", {7'd0, irq_o}, 8'h00);
        reg_read(8'd12, v); chk("R6 update no enable", v, 8'h10);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        reg_write(8'd11, 8'h12);
        bus_write(1'b0, 8'd12);
        @(negedge clk);
        bus_addr = 1'b1; bus_rd = 1'b1; uf_req = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; uf_req = 1'b0;
        chk("R9 read returns old", v, 8'h00);
        chk("R9 irq kept", {7'd0, irq_o}, 8'h01);
        bus_read(1'b1, v); chk("R9 flag survives", v, 8'h90);
        reg_write(8'd11, 8'h02);
    endtask

    task automatic t_soft_reset;
        logic [7:0] v;
        reg_write(8'd11, 8'h6E);
        reg_write(8'd10, 8'h2B);
        pulse(pf_req);
        chk("R7 irq before soft reset", {7'd0, irq_o}, 8'h01);
        pulse(soft_rst);
        chk("R11 irq low", {7'd0, irq_o}, 8'h00);
        reg_read(8'd11, v); chk("R11 B enables cleared", v, 8'h06);
        reg_read(8'd12, v); chk("R11 C cleared", v, 8'h00);
        reg_read(8'd10, v); chk("R11 A kept", v, 8'h2B);
        reg_read(8'h7A, v); chk("R11 storage kept", v, 8'h5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        t_power_up();
        t_index_storage();
        t_read_only();
        t_uip();
        t_set_mode();
        t_flags();
        t_collision();
        t_soft_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0x00 expected=0x01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule